// File: doc/BRIEF.md
# Inhibit-Gated Angle Word Reader

This block sits on the host side of a tracking angle converter whose 16-bit result sits behind two active-low byte enables. It also has an active-low inhibit line that freezes the converter's output latch. When the host requests a read, the block pulls inhibit low and holds it there. After a minimum setup time it opens the enables and samples the data lines once they have settled. It then closes the enables and waits out a bus-release window. Finally it lifts inhibit and enforces a refresh gap before it will take the next request.

The read runs in one of two capture styles, selected per read by a mode pin. In split style the two halves share an 8-bit lane (`conv_d[7:0]`). The high half is taken first and the low half second, and only one enable is low at a time. In wide style both enables open together and all 16 lines are taken in one capture. Every time limit is given in nanoseconds and rounded up to whole clock cycles from a clock-period parameter. A single down-counter times each window.

The request side is a valid/ready channel. `req_ready` is high only while the reader is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A request raised while `req_ready` is low has no effect, and nothing is queued for it. The result side has no back-pressure. `angle_done` pulses for one cycle, and `angle_word` keeps its value until the next pulse, so a consumer may read it at any time.

Top module: `angle_bus_reader`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the block holds `conv_inh_n`, `conv_hbe_n` and `conv_lbe_n` at 1, `angle_word` at 0, `angle_done` at 0 and `req_ready` at 1.
- R2: A request is taken only on an edge where `req_ready` is 1, and `conv_inh_n` is 0 in the cycle right after that edge. A `req_valid` raised while `req_ready` is 0 starts nothing.
- R3: `conv_hbe_n` falls S cycles after `conv_inh_n` falls. Here S = max(ceil(350 ns/T), ceil(500 ns/T) − ceil(150 ns/T)), T is the clock period, and every ceiling is at least 1. No enable is low while `conv_inh_n` is high.
- R4: Split style (mode 0): `conv_hbe_n` stays low for H = ceil(150 ns/T) cycles. The value on `conv_d[7:0]` in the last of those cycles becomes `angle_word[15:8]`, with `conv_d[7]` as the word's MSB. `conv_lbe_n` falls in the same cycle that `conv_hbe_n` rises, and the two are never low together.
- R5: Split style: `conv_lbe_n` stays low for H cycles. The value on `conv_d[7:0]` in the last of those cycles becomes `angle_word[7:0]`.
- R6: Wide style (mode 1): both enables fall together, S cycles after inhibit falls, and rise together H cycles later. The whole `conv_d[15:0]` in the last low cycle becomes `angle_word`, bit for bit.
- R7: The style is taken from `wide_mode` on the accepting edge. A change of `wide_mode` during a read does not alter that read.
- R8: `angle_done` is 1 for exactly one cycle per read. That cycle comes R = ceil(100 ns/T) cycles after the last enable rises, and `conv_inh_n` returns to 1 in the same cycle.
- R9: `angle_word` changes only in a cycle where `angle_done` is 1.
- R10: `req_ready` returns to 1 exactly F = ceil(100 ns/T) cycles after the `angle_done` cycle. Inhibit and both enables are 1 whenever `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Reader idle; a request is taken this edge |
| wide_mode | input | 1 | Capture style for the read: 0 split, 1 wide |
| conv_inh_n | output | 1 | Active-low latch freeze to the converter |
| conv_hbe_n | output | 1 | Active-low high-half enable |
| conv_lbe_n | output | 1 | Active-low low-half enable |
| conv_d | input | 16 | Converter data lines (split style uses bits 7:0) |
| angle_word | output | 16 | Last assembled angle word |
| angle_done | output | 1 | One-cycle pulse when `angle_word` is updated |

## Verification
The bench stands in for the converter. Its angle changes every cycle while inhibit is high and freezes while inhibit is low. It drives correct data only once the relevant enable has been low for H cycles and inhibit for the 500 ns count, and drives corrupted bits at every other moment. An early capture, a wrong byte lane or a capture taken before inhibit settled therefore shows up as a wrong word. Reads are run in split and wide style, back to back with the request held at the moment `req_ready` returns, and under a stream of busy-time requests with `wide_mode` toggled at random. The busy-time run separates a correct reader from one that accepts requests or changes style mid-read. The edge positions of every pin are measured and compared against the derived S, H, R and F.

// File: rtl/abr_pkg.sv
package abr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_REL,
    ST_REFR
  } abr_state_e;

  // Whole cycles covering a time span, never fewer than one.
  function automatic int ns_to_cyc(input int span_ns, input int period_ns);
    int c;
    c = (span_ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/abr_timer.sv
module abr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/abr_seq.sv
module abr_seq
  import abr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int N_SETUP = 1,
  parameter int N_HOLD  = 1,
  parameter int N_REL   = 1,
  parameter int N_REFR  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             wide_mode,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             req_ready,
  output logic             mode_q,
  output logic             cap_hi,
  output logic             cap_lo,
  output logic             cap_full,
  output logic             publish,
  output logic             inh_n,
  output logic             hbe_n,
  output logic             lbe_n
);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(N_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(N_HOLD - 1);
  localparam logic [CNT_W-1:0] LD_REL   = CNT_W'(N_REL - 1);
  localparam logic [CNT_W-1:0] LD_REFR  = CNT_W'(N_REFR - 1);

  abr_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_hi   = 1'b0;
    cap_lo   = 1'b0;
    cap_full = 1'b0;
    publish  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d     = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = LD_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          st_d     = ST_HIGH;
          tmr_load = 1'b1;
          tmr_val  = LD_HOLD;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (mode_q) begin
            cap_full = 1'b1;
            st_d     = ST_REL;
            tmr_val  = LD_REL;
          end else begin
            cap_hi  = 1'b1;
            st_d    = ST_LOW;
            tmr_val = LD_HOLD;
          end
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          cap_lo   = 1'b1;
          st_d     = ST_REL;
          tmr_load = 1'b1;
          tmr_val  = LD_REL;
        end
      end
      ST_REL: begin
        if (tmr_zero) begin
          publish  = 1'b1;
          st_d     = ST_REFR;
          tmr_load = 1'b1;
          tmr_val  = LD_REFR;
        end
      end
      ST_REFR: begin
        if (tmr_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid) mode_q <= wide_mode;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign inh_n     = (st_q == ST_IDLE) || (st_q == ST_REFR);
  assign hbe_n     = (st_q != ST_HIGH);
  assign lbe_n     = !((st_q == ST_LOW) || (st_q == ST_HIGH && mode_q));

endmodule

// File: rtl/abr_assemble.sv
module abr_assemble #(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_hi,
  input  logic                cap_lo,
  input  logic                cap_full,
  input  logic                publish,
  input  logic [2*LANE_W-1:0] bus_d,
  output logic [2*LANE_W-1:0] word_q,
  output logic                done_q
);

  localparam int WORD_W = 2 * LANE_W;

  logic [WORD_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (cap_full) begin
      shadow_q <= bus_d;
    end else begin
      if (cap_hi) shadow_q[WORD_W-1:LANE_W] <= bus_d[LANE_W-1:0];
      if (cap_lo) shadow_q[LANE_W-1:0]      <= bus_d[LANE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= publish;
      if (publish) word_q <= shadow_q;
    end
  end

endmodule

// File: rtl/angle_bus_reader.sv
module angle_bus_reader
  import abr_pkg::*;
#(
  parameter int CLK_NS      = 4,
  parameter int LANE_W      = 8,
  parameter int INH_MIN_NS  = 500,
  parameter int SETUP_NS    = 350,
  parameter int HOLD_NS     = 150,
  parameter int RELEASE_NS  = 100,
  parameter int REFRESH_NS  = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                wide_mode,
  output logic                conv_inh_n,
  output logic                conv_hbe_n,
  output logic                conv_lbe_n,
  input  logic [2*LANE_W-1:0] conv_d,
  output logic [2*LANE_W-1:0] angle_word,
  output logic                angle_done
);

  localparam int C_INH   = ns_to_cyc(INH_MIN_NS, CLK_NS);
  localparam int C_HOLD  = ns_to_cyc(HOLD_NS, CLK_NS);
  localparam int C_SETUP = imax(ns_to_cyc(SETUP_NS, CLK_NS), imax(1, C_INH - C_HOLD));
  localparam int C_REL   = ns_to_cyc(RELEASE_NS, CLK_NS);
  localparam int C_REFR  = ns_to_cyc(REFRESH_NS, CLK_NS);
  localparam int C_MAX   = imax(imax(C_SETUP, C_HOLD), imax(C_REL, C_REFR));
  localparam int CNT_W   = $clog2(C_MAX + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             mode_q;
  logic             cap_hi, cap_lo, cap_full, publish;

  abr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  abr_seq #(
    .CNT_W   (CNT_W),
    .N_SETUP (C_SETUP),
    .N_HOLD  (C_HOLD),
    .N_REL   (C_REL),
    .N_REFR  (C_REFR)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .wide_mode (wide_mode),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .req_ready (req_ready),
    .mode_q    (mode_q),
    .cap_hi    (cap_hi),
    .cap_lo    (cap_lo),
    .cap_full  (cap_full),
    .publish   (publish),
    .inh_n     (conv_inh_n),
    .hbe_n     (conv_hbe_n),
    .lbe_n     (conv_lbe_n)
  );

  abr_assemble #(.LANE_W(LANE_W)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .cap_hi   (cap_hi),
    .cap_lo   (cap_lo),
    .cap_full (cap_full),
    .publish  (publish),
    .bus_d    (conv_d),
    .word_q   (angle_word),
    .done_q   (angle_done)
  );

endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              inh_n,
  input logic              hbe_n,
  input logic              lbe_n,
  input logic              done,
  input logic [WORD_W-1:0] word,
  input logic              mode_q
);

  p_accept_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(inh_n) |-> $past(req_valid && req_ready));

  p_enable_under_inhibit_r3: assert property (@(posedge clk) disable iff (rst)
    (!hbe_n || !lbe_n) |-> !inh_n);

  p_split_one_enable_r4: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (hbe_n || lbe_n));

  p_wide_paired_r6: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> (hbe_n == lbe_n));

  p_mode_steady_r7: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> $stable(mode_q));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_released_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (inh_n && hbe_n && lbe_n && !req_ready));

  p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(word));

  p_ready_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (inh_n && hbe_n && lbe_n));

endmodule

bind angle_bus_reader abr_checker #(.WORD_W(2*LANE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .inh_n     (conv_inh_n),
  .hbe_n     (conv_hbe_n),
  .lbe_n     (conv_lbe_n),
  .done      (angle_done),
  .word      (angle_word),
  .mode_q    (mode_q)
);

// File: tb/sim_angle_bus_reader.sv
`timescale 1ns/1ps
module sim_angle_bus_reader;

  localparam int PER = 4;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int H  = cyc(150);
  localparam int I  = cyc(500);
  localparam int S  = (cyc(350) > I - H) ? cyc(350) : I - H;
  localparam int R  = cyc(100);
  localparam int F  = cyc(100);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        wide_mode = 1'b0;
  logic        req_ready, conv_inh_n, conv_hbe_n, conv_lbe_n, angle_done;
  logic [15:0] conv_d, angle_word;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  angle_bus_reader u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .wide_mode(wide_mode), .conv_inh_n(conv_inh_n), .conv_hbe_n(conv_hbe_n),
    .conv_lbe_n(conv_lbe_n), .conv_d(conv_d), .angle_word(angle_word),
    .angle_done(angle_done)
  );

  // Converter stand-in: angle moves while inhibit is high, data valid only after settle.
  logic [15:0] conv_angle = 16'h0;
  int hcnt = 0, lcnt = 0, icnt = 0;

  always @(posedge clk) begin
    if (conv_inh_n) conv_angle <= 16'($urandom);
    hcnt <= conv_hbe_n ? 0 : hcnt + 1;
    lcnt <= conv_lbe_n ? 0 : lcnt + 1;
    icnt <= conv_inh_n ? 0 : icnt + 1;
  end

  always_comb begin
    conv_d = conv_angle ^ 16'h5AA5 ^ {conv_angle[7:0], conv_angle[15:8]} ^ 16'h0101;
    if (!conv_hbe_n && !conv_lbe_n) begin
      if (hcnt >= H - 1 && icnt >= I - 1) conv_d = conv_angle;
    end else if (!conv_hbe_n) begin
      if (hcnt >= H - 1 && icnt >= I - 1) conv_d[7:0] = conv_angle[15:8];
    end else if (!conv_lbe_n) begin
      if (lcnt >= H - 1 && icnt >= I - 1) conv_d[7:0] = conv_angle[7:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic wide, input bit spam);
    int t = 1;
    int t_inh = -1, t_hf = -1, t_hr = -1, t_lf = -1, t_lr = -1;
    int t_done = -1, t_inhr = -1, t_rdy = -1, dones = 0;
    logic [15:0] exp_w = '0, prev_w;
    bit moved = 0;
    while (!req_ready) @(negedge clk);
    prev_w = angle_word;
    wide_mode = wide;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (t_rdy < 0 && t < 3000) begin
      if (!conv_inh_n && t_inh < 0) begin t_inh = t; exp_w = conv_angle; end
      if (!conv_hbe_n && t_hf < 0) t_hf = t;
      if (conv_hbe_n && t_hf >= 0 && t_hr < 0) t_hr = t;
      if (!conv_lbe_n && t_lf < 0) t_lf = t;
      if (conv_lbe_n && t_lf >= 0 && t_lr < 0) t_lr = t;
      if (angle_done) begin dones++; if (t_done < 0) t_done = t; end
      if (conv_inh_n && t_inh >= 0 && t_inhr < 0) t_inhr = t;
      if (req_ready && t_done >= 0) t_rdy = t;
      if (t_done < 0 && angle_word !== prev_w) moved = 1;
      if (spam && t_done < 0 && !angle_done) begin
        req_valid = 1'($urandom);
        wide_mode = 1'($urandom);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      t++;
    end
    chk(t_inh == 1, "R2 inhibit after accept", t_inh, 1);
    chk(t_hf - t_inh == S, "R3 setup cycles", t_hf - t_inh, S);
    if (wide) begin
      chk(t_lf == t_hf && t_lr == t_hr, "R6 enables paired", t_lf, t_hf);
      chk(t_hr - t_hf == H, "R6 hold cycles", t_hr - t_hf, H);
      chk(angle_word == exp_w, "R6 wide word", angle_word, exp_w);
    end else begin
      chk(t_hr - t_hf == H, "R4 high hold", t_hr - t_hf, H);
      chk(t_lf == t_hr, "R4 handover", t_lf, t_hr);
      chk(t_lr - t_lf == H, "R5 low hold", t_lr - t_lf, H);
      chk(angle_word[15:8] == exp_w[15:8], "R4 high byte", angle_word[15:8], exp_w[15:8]);
      chk(angle_word[7:0] == exp_w[7:0], "R5 low byte", angle_word[7:0], exp_w[7:0]);
    end
    if (spam) chk(t_lf >= 0 && ((wide && t_lf == t_hf) || (!wide && t_lf == t_hr)),
                  "R7 style latched", t_lf, wide ? t_hf : t_hr);
    chk(t_done - t_lr == R && dones == 1, "R8 done timing", t_done - t_lr, R);
    chk(t_inhr == t_done, "R8 inhibit release", t_inhr, t_done);
    chk(!moved, "R9 word held", angle_word, prev_w);
    chk(t_rdy - t_done == F, "R10 refresh gap", t_rdy - t_done, F);
    if (spam) begin
      repeat (3) @(negedge clk);
      chk(conv_inh_n && req_ready, "R2 busy request ignored", conv_inh_n, 1);
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(conv_inh_n && conv_hbe_n && conv_lbe_n && req_ready && !angle_done && angle_word == 0,
        "R1 reset state", {conv_inh_n, conv_hbe_n, conv_lbe_n, req_ready, angle_done}, 5'b11110);
    rst = 1'b0;
    @(negedge clk);
    chk(conv_inh_n && req_ready && angle_word == 0, "R1 after reset", angle_word, 0);
    do_read(1'b0, 1'b0);
    do_read(1'b1, 1'b0);
    do_read(1'b0, 1'b1);
    do_read(1'b1, 1'b1);
    do_read(1'b1, 1'b0);
    do_read(1'b0, 1'b0);
    for (int k = 0; k < 30; k++) begin
      do_read(1'($urandom), 1'($urandom));
      repeat ($urandom % 4) @(negedge clk);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule